// File: doc/BRIEF.md
# Request-Triggered Serial Record Source

This block stands in for a navigation receiver on a test bench. A controller under test raises a request line at the start of every telemetry frame. On the rising edge of that request the block sends one fixed 125-byte measurement record, 1000 bits in all, on a serial data line with an accompanying bit clock. The record sits in an internal byte-wide register file that the host side loads through a simple write port.

The bit period is a parameter counted in system clocks. With the default of 500 clocks at 125 MHz the line runs at 250 kbit/s, so a record takes 4 ms and ends well inside the 8 ms allowed after each request and before the next frame's request. A request that rises while a record is still being sent is not served; it sets a sticky overrun flag instead.

Top module: `req_serial_source`

## Requirements
- R1: After reset, busy_o, sdata_o, sclk_o and overrun_o are all 0 and every record byte reads as 0x00.
- R2: A 0-to-1 change of the asynchronous req_i, passed through a two-flop synchronizer, starts a record; busy_o rises within 4 clock cycles of the change, and req_i held high afterwards starts no further record.
- R3: Each record is exactly 1000 bits (125 bytes): busy_o stays high for exactly 1000 × BIT_DIV clock cycles and sclk_o shows exactly 1000 rising edges in that time.
- R4: Bytes leave in address order 0 to 124, each with bit 7 first and bit 0 last; a receiver samples sdata_o on the rising edge of sclk_o.
- R5: Each bit period is BIT_DIV clock cycles; sclk_o is 0 for the first BIT_DIV/2 cycles and 1 for the rest, and sdata_o changes only at the start of a bit period.
- R6: While busy_o is 0, sdata_o and sclk_o are both 0.
- R7: A rising edge of req_i while busy_o is 1 sets overrun_o, does not restart or alter the record in progress, and starts no record afterwards.
- R8: Once set, overrun_o stays 1 until reset, across later complete records.
- R9: A write with wr_en_i high stores wr_data_i at byte address wr_addr_i on the next clock; a write to an address of 125 or above changes no byte of the record.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Data request from the controller, asynchronous |
| wr_en_i | input | 1 | Record byte write strobe |
| wr_addr_i | input | 7 | Record byte address |
| wr_data_i | input | 8 | Record byte value |
| sclk_o | output | 1 | Serial bit clock, idle low |
| sdata_o | output | 1 | Serial data, MSB first, idle low |
| busy_o | output | 1 | High from the first bit through the last bit |
| overrun_o | output | 1 | Sticky flag: request arrived during a record |

## Verification
A wrong bit or byte counter shows at once as a busy pulse of the wrong length and a clock edge count other than 1000, visible at the falling edge of busy_o. A slip in the divider shows within the first bit period as sclk_o high in the wrong cycles or data moving while the clock is high. A stale shift register or wrong read address shows as a mismatched byte in the captured stream, located to its byte position, and a broken overrun path shows as a restarted record or a second busy pulse right after the first.

// File: rtl/srcq_pkg.sv
package srcq_pkg;

    typedef enum logic {
        PH_IDLE = 1'b0,
        PH_SEND = 1'b1
    } phase_e;

    localparam int BITS_PER_BYTE = 8;

endpackage

// File: rtl/srcq_edge.sv
module srcq_edge (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic async_i,
    output logic rise_o
);
    logic meta_q, sync_q, prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
            prev_q <= 1'b0;
        end else begin
            meta_q <= async_i;
            sync_q <= meta_q;
            prev_q <= sync_q;
        end
    end

    assign rise_o = sync_q & ~prev_q;

    // R2: a detected edge is a single-cycle pulse
    assert_rise_single_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rise_o |=> !rise_o);
endmodule

// File: rtl/srcq_record.sv
module srcq_record #(
    parameter int NUM_BYTES = 125,
    parameter int AW        = 7
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [7:0]    wr_data_i,
    input  logic [AW-1:0] rd_addr_i,
    output logic [7:0]    rd_data_o
);
    logic [7:0] mem_q [NUM_BYTES];

    for (genvar g = 0; g < NUM_BYTES; g++) begin : g_byte
        always_ff @(posedge clk_i or negedge rst_ni) begin
            if (!rst_ni) begin
                mem_q[g] <= 8'h00;
            end else if (wr_en_i && (wr_addr_i == AW'(g))) begin
                mem_q[g] <= wr_data_i;
            end
        end
    end

    always_comb begin
        rd_data_o = 8'h00;
        for (int i = 0; i < NUM_BYTES; i++) begin
            if (rd_addr_i == AW'(i)) begin
                rd_data_o = mem_q[i];
            end
        end
    end
endmodule

// File: rtl/req_serial_source.sv
module req_serial_source #(
    parameter int NUM_BYTES = 125,
    parameter int BIT_DIV   = 500,
    parameter int AW        = 7
) (
    input  logic          clk_i,
    input  logic          rst_ni,
    input  logic          req_i,
    input  logic          wr_en_i,
    input  logic [AW-1:0] wr_addr_i,
    input  logic [7:0]    wr_data_i,
    output logic          sclk_o,
    output logic          sdata_o,
    output logic          busy_o,
    output logic          overrun_o
);
    import srcq_pkg::*;

    localparam int DW = (BIT_DIV > 2) ? $clog2(BIT_DIV) : 1;
    localparam logic [DW-1:0] DIV_LAST  = DW'(BIT_DIV - 1);
    localparam logic [DW-1:0] DIV_HALF  = DW'(BIT_DIV / 2);
    localparam logic [AW-1:0] BYTE_LAST = AW'(NUM_BYTES - 1);
    localparam logic [2:0]    BIT_LAST  = 3'(BITS_PER_BYTE - 1);
    localparam int TOTAL_BITS = NUM_BYTES * BITS_PER_BYTE;
    localparam int TOTAL_CYC  = TOTAL_BITS * BIT_DIV;

    typedef struct packed {
        phase_e        phase;
        logic          overrun;
        logic [DW-1:0] div;
        logic [2:0]    bit_idx;
        logic [AW-1:0] byte_idx;
        logic [7:0]    shreg;
    } state_t;

    state_t        st_d, st_q;
    logic          req_rise;
    logic [AW-1:0] rd_addr;
    logic [7:0]    rd_data;

    srcq_edge i_edge (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(req_i),
        .rise_o (req_rise)
    );

    srcq_record #(.NUM_BYTES(NUM_BYTES), .AW(AW)) i_record (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .wr_en_i  (wr_en_i),
        .wr_addr_i(wr_addr_i),
        .wr_data_i(wr_data_i),
        .rd_addr_i(rd_addr),
        .rd_data_o(rd_data)
    );

    always_comb begin
        st_d    = st_q;
        rd_addr = (st_q.phase == PH_IDLE) ? '0 : st_q.byte_idx + AW'(1);
        unique case (st_q.phase)
            PH_IDLE: begin
                if (req_rise) begin
                    st_d.phase    = PH_SEND;
                    st_d.div      = '0;
                    st_d.bit_idx  = '0;
                    st_d.byte_idx = '0;
                    st_d.shreg    = rd_data;
                end
            end
            PH_SEND: begin
                if (req_rise) begin
                    st_d.overrun = 1'b1;
                end
                if (st_q.div == DIV_LAST) begin
                    st_d.div = '0;
                    if (st_q.bit_idx == BIT_LAST) begin
                        st_d.bit_idx = '0;
                        if (st_q.byte_idx == BYTE_LAST) begin
                            st_d.phase = PH_IDLE;
                            st_d.shreg = '0;
                        end else begin
                            st_d.byte_idx = st_q.byte_idx + AW'(1);
                            st_d.shreg    = rd_data;
                        end
                    end else begin
                        st_d.bit_idx = st_q.bit_idx + 3'd1;
                        st_d.shreg   = {st_q.shreg[6:0], 1'b0};
                    end
                end else begin
                    st_d.div = st_q.div + DW'(1);
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            st_q <= '{phase: PH_IDLE, overrun: 1'b0, div: '0, bit_idx: '0,
                      byte_idx: '0, shreg: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign busy_o    = (st_q.phase == PH_SEND);
    assign sclk_o    = busy_o && (st_q.div >= DIV_HALF);
    assign sdata_o   = busy_o && st_q.shreg[7];
    assign overrun_o = st_q.overrun;

    // Observation counters for the checks below
    logic [31:0] chk_busy_len_q, chk_edges_q;
    logic        chk_sclk_prev_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            chk_busy_len_q  <= '0;
            chk_edges_q     <= '0;
            chk_sclk_prev_q <= 1'b0;
        end else begin
            chk_sclk_prev_q <= sclk_o;
            if (!busy_o) begin
                chk_busy_len_q <= '0;
                chk_edges_q    <= '0;
            end else begin
                chk_busy_len_q <= chk_busy_len_q + 32'd1;
                if (sclk_o && !chk_sclk_prev_q) begin
                    chk_edges_q <= chk_edges_q + 32'd1;
                end
            end
        end
    end

    assert_idle_quiet_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !busy_o |-> (!sdata_o && !sclk_o));

    assert_overrun_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        overrun_o |=> overrun_o);

    assert_overrun_set_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_rise && busy_o) |=> (overrun_o && busy_o));

    assert_data_steady_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(sclk_o) |-> $stable(sdata_o));

    assert_busy_len_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> (chk_busy_len_q == 32'(TOTAL_CYC)));

    assert_edge_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(busy_o) |-> (chk_edges_q == 32'(TOTAL_BITS)));
endmodule

// File: tb/test_req_serial_source.sv
module test_req_serial_source;
    localparam int NB    = 125;
    localparam int DIV   = 4;
    localparam int NBITS = NB * 8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       req = 1'b0;
    logic       wr_en = 1'b0;
    logic [6:0] wr_addr = '0;
    logic [7:0] wr_data = '0;
    logic       sclk, sdata, busy, overrun;

    int         n_checks = 0;
    int         n_errors = 0;
    logic [7:0] model [NB];
    logic       cap [NBITS];
    logic       done = 1'b0;

    always #4 clk = ~clk;

    req_serial_source #(.NUM_BYTES(NB), .BIT_DIV(DIV), .AW(7)) i_req_serial_source (
        .clk_i(clk), .rst_ni(rst_n), .req_i(req), .wr_en_i(wr_en),
        .wr_addr_i(wr_addr), .wr_data_i(wr_data), .sclk_o(sclk),
        .sdata_o(sdata), .busy_o(busy), .overrun_o(overrun)
    );

    task automatic check(input bit ok, input string rq, input string what,
                         input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual=%0d expected=%0d", rq, what, act, exp);
        end
    endtask

    task automatic write_byte(input int addr, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 7'(addr); wr_data = 8'(val);
        @(negedge clk);
        wr_en = 1'b0;
        if (addr < NB) model[addr] = 8'(val);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; req = 1'b0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        for (int i = 0; i < NB; i++) model[i] = 8'h00;
        @(negedge clk);
    endtask

    // Runs one record; inject=1 raises a second request mid-record
    task automatic run_record(input string tag, input bit inject);
        int lat = 0, c = 0, nbits = 0, clk_err = 0, dat_err = 0, bad = 0;
        int first_bad = -1, got = 0, quiet_err = 0;
        logic prev_sclk = 1'b0, prev_data = 1'b0;
        @(negedge clk);
        req = 1'b1;
        while (!busy && lat < 10) begin @(negedge clk); lat++; end
        check(lat <= 4, "R2", {tag, " start latency"}, lat, 4);
        while (busy && c < 2 * NBITS * DIV) begin
            if (sclk !== ((c % DIV) >= DIV / 2)) clk_err++;
            if ((c % DIV) != 0 && c != 0 && sdata !== prev_data) dat_err++;
            if (sclk && !prev_sclk) begin
                if (nbits < NBITS) cap[nbits] = sdata;
                nbits++;
            end
            prev_sclk = sclk; prev_data = sdata;
            if (inject && c == 10)  req = 1'b0;
            if (inject && c == 200) req = 1'b1;
            if (inject && c == 220) req = 1'b0;
            @(negedge clk);
            c++;
        end
        check(c == NBITS * DIV, "R3", {tag, " busy cycles"}, c, NBITS * DIV);
        check(nbits == NBITS, "R3", {tag, " clock edges"}, nbits, NBITS);
        check(clk_err == 0, "R5", {tag, " sclk phase errors"}, clk_err, 0);
        check(dat_err == 0, "R5", {tag, " mid-bit data changes"}, dat_err, 0);
        for (int b = 0; b < NB; b++) begin
            logic [7:0] v;
            for (int k = 0; k < 8; k++) v[7-k] = (8*b+k < nbits) ? cap[8*b+k] : 1'bx;
            if (v !== model[b]) begin
                bad++;
                if (first_bad < 0) begin first_bad = b; got = int'(v); end
            end
        end
        check(bad == 0, "R4", {tag, " record bytes (first bad shown)"},
              got, (first_bad < 0) ? 0 : int'(model[first_bad]));
        // request still high (or re-raised earlier): no new record may start
        for (int i = 0; i < 40; i++) begin
            if (busy || sdata || sclk) quiet_err++;
            @(negedge clk);
        end
        check(quiet_err == 0, inject ? "R7" : "R6", {tag, " quiet after record"},
              quiet_err, 0);
        req = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset();
        do_reset();
        check(busy == 1'b0 && sdata == 1'b0 && sclk == 1'b0, "R1",
              "outputs after reset", {busy, sdata, sclk}, 0);
        check(overrun == 1'b0, "R1", "overrun after reset", overrun, 0);
    endtask

    task automatic t_zero_record();
        run_record("R1 cleared record", 1'b0);
    endtask

    task automatic t_ramp();
        for (int i = 0; i < NB; i++) write_byte(i, (i * 7 + 3) & 8'hFF);
        run_record("R2 ramp", 1'b0);
        check(overrun == 1'b0, "R2", "held request not an overrun", overrun, 0);
    endtask

    task automatic t_edges_and_bad_addr();
        for (int i = 0; i < NB; i++)
            write_byte(i, (i % 4 == 0) ? 8'h80 : (i % 4 == 1) ? 8'h01 :
                          (i % 4 == 2) ? 8'hA5 : 8'h5A);
        write_byte(125, 8'hFF);
        write_byte(127, 8'hFF);
        run_record("R9 pattern + ignored writes", 1'b0);
    endtask

    task automatic t_overrun();
        run_record("R7 overrun", 1'b1);
        check(overrun == 1'b1, "R7", "overrun set", overrun, 1);
        run_record("R8 later record", 1'b0);
        check(overrun == 1'b1, "R8", "overrun still set", overrun, 1);
        do_reset();
        check(overrun == 1'b0, "R8", "overrun cleared by reset", overrun, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_errors++;
            $display("FAIL watchdog expired: actual=%0d expected=%0d", 1, 0);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_zero_record();
        t_ramp();
        t_edges_and_bad_addr();
        t_overrun();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule